// File: doc/BRIEF.md
# Data Access Address Translator

This block turns the virtual address of a load or store into a physical address. It also returns a fault code and, when the access faults, a packed status word for the fault registers. A request presents the address, the access size, the direction and a set of qualifiers. The qualifiers are physical access, alternate-mode request, page-table load, no-fault and misspeculated. The request also carries the current and alternate privilege modes, bit 0 of the program counter, the opcode and register number of the instruction, and the result of a translation-buffer lookup that an external unit has already performed. All results appear registered one cycle after the request.

The checks follow a fixed precedence:

1. Alignment.
2. Physical bypass.
3. Virtual address validity.
4. Kernel-only superpage window.
5. Translation-buffer hit or miss.
6. Per-mode read or write enables and the page's fault-on-read and fault-on-write traps.

A fault updates the fault address, status and formatted-address registers. This update is skipped for misspeculated, page-table and no-fault requests. Saturating counters for hits, misses and violations, kept apart for loads and stores, are brought out for observation.

Top module: `data_xlate`

## Requirements
- R1: If any of the low `req_size` address bits is set (the access is 1, 2, 4 or 8 bytes for `req_size` 0 to 3), the fault code is 1 (alignment). The only cause flag set is the write flag, and only for a store. This check takes precedence over every other check, the physical bypass included, and it changes no counter.
- R2: The effective privilege mode (0 kernel, 1 executive, 2 supervisor, 3 user) is `cur_mode` while `pc_lsb` is 0. While `pc_lsb` is 1 it is `alt_mode` if `req_altmode` is set, and kernel otherwise. Permission and superpage checks use the effective mode.
- R3: An aligned request with `req_phys` set returns the low address bits unchanged as the physical address, with fault code 0, and changes no counter.
- R4: A virtual address whose bits 63 down to 42 are not all equal gives fault code 3 (page fault), with the bad-address and access-violation flags (plus the write flag for a store). It adds one to the violation counter.
- R5: An address whose bits 47:41 equal 0x7e lies in the superpage window. In kernel mode it maps to bits 39:0 of the address, with bit 40 copied into bits 43:40, and counts as a hit. In any other mode it gives fault code 2 (access violation) with the access-violation flag.
- R6: A translation-buffer miss sets the miss flag and adds one to the miss counter. The fault code is 5 for a page-table load and 4 otherwise.
- R7: A permitted hit returns the page number from the buffer joined to address bits 12:0 and counts a hit. On any fault the physical address output is zero.
- R8: A store whose effective-mode bit in `tlb_wr_en` is clear gives code 3 with the write and violation flags, plus the fault-on-write flag when the page trap is set. A permitted store to a page with its fault-on-write trap set gives code 3 with the write and fault-on-write flags.
- R9: A load whose effective-mode bit in `tlb_rd_en` is clear gives code 2 with the violation flag, plus the fault-on-read flag when that trap is set. A permitted load with the fault-on-read trap set gives code 3 with the fault-on-read flag only.
- R10: The status word carries the opcode in bits 16:11, the register number in bits 10:6 and the cause flags in bits 5:0. The flags are: write at bit 0, access violation at 1, fault-on-read at 2, fault-on-write at 3, miss at 4, bad address at 5.
- R11: The fault registers load only for a faulting request that is not misspeculated, not a page-table load and not a no-fault request. `fr_upd` then pulses with the response, `fr_va` takes the address, and `fr_vaform` takes `fmt_base` ORed with address bits 42:13 shifted left by 3. Otherwise all three registers hold.
- R12: Six counters exist, kept apart for loads and stores: hits, misses and violations. Each saturates at all ones.
- R13: Synchronous reset clears every output. `rsp_valid` follows `req_valid` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | VA_W | Virtual address |
| req_size | input | SIZE_W | Log2 of access size in bytes |
| req_write | input | 1 | 1 for a store |
| req_phys | input | 1 | Physical access, translation bypassed |
| req_altmode | input | 1 | Use alternate mode under the PC override |
| req_ptload | input | 1 | Page-table load |
| req_nofault | input | 1 | Fault registers must not load |
| req_misspec | input | 1 | Request is misspeculated |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| pc_lsb | input | 1 | Bit 0 of the program counter |
| req_opcode | input | 6 | Instruction opcode |
| req_regnum | input | 5 | Instruction register number |
| fmt_base | input | VA_W | Base for the formatted fault address |
| tlb_hit | input | 1 | Translation buffer hit |
| tlb_ppn | input | PA_W-PAGE_SHIFT | Physical page number on hit |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fault_rd | input | 1 | Page fault-on-read trap |
| tlb_fault_wr | input | 1 | Page fault-on-write trap |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | PA_W | Physical address |
| rsp_fault | output | 3 | Fault code (0 none, 1 align, 2 violation, 3 page, 4 miss, 5 page-table miss) |
| fr_upd | output | 1 | Fault registers loaded with this response |
| fr_va | output | VA_W | Fault address register |
| fr_stat | output | 17 | Fault status word register |
| fr_vaform | output | VA_W | Formatted fault address register |
| cnt_rd_hit | output | CNT_W | Load hit counter |
| cnt_rd_miss | output | CNT_W | Load miss counter |
| cnt_rd_acv | output | CNT_W | Load violation counter |
| cnt_wr_hit | output | CNT_W | Store hit counter |
| cnt_wr_miss | output | CNT_W | Store miss counter |
| cnt_wr_acv | output | CNT_W | Store violation counter |

## Verification
Two pairs of functions can act on the same request. In the first, a misaligned access also carries a buffer miss, a denied permission or the physical flag. The alignment sweep provokes this by crossing every size and offset with both directions and the physical flag. The result is judged by the alignment code, the lone write flag and counters that do not move. In the second, a miss that counts also has its fault-register update suppressed. This is provoked by crossing the page-table, no-fault and misspeculated qualifiers. The result is judged by the miss counter advancing while `fr_upd` stays low and the fault registers keep their previous contents.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
  typedef enum logic [2:0] {
    FC_NONE  = 3'd0,
    FC_ALIGN = 3'd1,
    FC_ACV   = 3'd2,
    FC_PAGE  = 3'd3,
    FC_NMISS = 3'd4,
    FC_PMISS = 3'd5
  } fcode_t;

  localparam int MODE_W = 2;
  localparam int NMODES = 1 << MODE_W;
  localparam logic [MODE_W-1:0] MODE_KERNEL = '0;

  localparam int OPC_W  = 6;
  localparam int REG_W  = 5;
  localparam int NFLAGS = 6;
  localparam int STAT_W = OPC_W + REG_W + NFLAGS;

  // cause flag positions inside the status word
  localparam int FL_WR    = 0;
  localparam int FL_ACV   = 1;
  localparam int FL_FOR   = 2;
  localparam int FL_FOW   = 3;
  localparam int FL_MISS  = 4;
  localparam int FL_BADVA = 5;

  // counter bank layout: loads first, then stores
  localparam int K_HIT  = 0;
  localparam int K_MISS = 1;
  localparam int K_ACV  = 2;
  localparam int NKIND  = 3;
  localparam int NCNT   = 2 * NKIND;
endpackage

// File: rtl/dxl_mode_sel.sv
module dxl_mode_sel
  import dxl_pkg::*;
(
  input  logic              pc_lsb,
  input  logic              use_alt,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [MODE_W-1:0] alt_mode,
  output logic [MODE_W-1:0] eff_mode
);
  always_comb begin
    if (!pc_lsb)      eff_mode = cur_mode;
    else if (use_alt) eff_mode = alt_mode;
    else              eff_mode = MODE_KERNEL;
  end
endmodule

// File: rtl/dxl_addr_class.sv
module dxl_addr_class #(
  parameter int VA_W       = 64,
  parameter int VA_IMPL    = 43,
  parameter int PA_W       = 44,
  parameter int SIZE_W     = 2,
  parameter int SP_LO      = 41,
  parameter int SP_HI      = 47,
  parameter int SP_TAG     = 126,
  parameter int SP_EXT_BIT = 40
) (
  input  logic [VA_W-1:0]   vaddr,
  input  logic [SIZE_W-1:0] size_log2,
  output logic              misaligned,
  output logic              va_ok,
  output logic              in_sp,
  output logic [PA_W-1:0]   sp_paddr
);
  localparam int MAX_LOG = (1 << SIZE_W) - 1;
  localparam int TOP_W   = VA_W - VA_IMPL + 1;
  localparam int SP_W    = SP_HI - SP_LO + 1;
  localparam int EXT_W   = PA_W - SP_EXT_BIT;

  logic [MAX_LOG-1:0] low_hit;
  logic [TOP_W-1:0]   top_bits;

  genvar g;
  generate
    for (g = 0; g < MAX_LOG; g++) begin : g_low
      assign low_hit[g] = vaddr[g] && (int'(size_log2) > g);
    end
  endgenerate

  assign misaligned = |low_hit;
  assign top_bits   = vaddr[VA_W-1:VA_IMPL-1];
  assign va_ok      = (&top_bits) || !(|top_bits);
  assign in_sp      = (vaddr[SP_HI:SP_LO] == SP_W'(SP_TAG));
  assign sp_paddr   = {{EXT_W{vaddr[SP_EXT_BIT]}}, vaddr[SP_EXT_BIT-1:0]};
endmodule

// File: rtl/dxl_perm_check.sv
module dxl_perm_check
  import dxl_pkg::*;
(
  input  logic              is_write,
  input  logic [MODE_W-1:0] mode,
  input  logic [NMODES-1:0] rd_en,
  input  logic [NMODES-1:0] wr_en,
  input  logic              trap_rd,
  input  logic              trap_wr,
  output logic              deny,
  output fcode_t            code,
  output logic [NFLAGS-1:0] flags
);
  always_comb begin
    deny  = 1'b0;
    code  = FC_NONE;
    flags = '0;
    if (is_write) begin
      if (!wr_en[mode]) begin
        deny          = 1'b1;
        code          = FC_PAGE;
        flags[FL_WR]  = 1'b1;
        flags[FL_ACV] = 1'b1;
        flags[FL_FOW] = trap_wr;
      end else if (trap_wr) begin
        deny          = 1'b1;
        code          = FC_PAGE;
        flags[FL_WR]  = 1'b1;
        flags[FL_FOW] = 1'b1;
      end
    end else begin
      if (!rd_en[mode]) begin
        deny          = 1'b1;
        code          = FC_ACV;
        flags[FL_ACV] = 1'b1;
        flags[FL_FOR] = trap_rd;
      end else if (trap_rd) begin
        deny          = 1'b1;
        code          = FC_PAGE;
        flags[FL_FOR] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dxl_sat_ctr.sv
module dxl_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)                    count <= '0;
    else if (inc && count != '1) count <= count + W'(1);
  end
endmodule

// File: rtl/data_xlate.sv
module data_xlate
  import dxl_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int VA_IMPL    = 43,
  parameter int PA_W       = 44,
  parameter int PAGE_SHIFT = 13,
  parameter int SIZE_W     = 2,
  parameter int SP_LO      = 41,
  parameter int SP_HI      = 47,
  parameter int SP_TAG     = 126,
  parameter int SP_EXT_BIT = 40,
  parameter int CNT_W      = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic [VA_W-1:0]            req_vaddr,
  input  logic [SIZE_W-1:0]          req_size,
  input  logic                       req_write,
  input  logic                       req_phys,
  input  logic                       req_altmode,
  input  logic                       req_ptload,
  input  logic                       req_nofault,
  input  logic                       req_misspec,
  input  logic [1:0]                 cur_mode,
  input  logic [1:0]                 alt_mode,
  input  logic                       pc_lsb,
  input  logic [5:0]                 req_opcode,
  input  logic [4:0]                 req_regnum,
  input  logic [VA_W-1:0]            fmt_base,
  input  logic                       tlb_hit,
  input  logic [PA_W-PAGE_SHIFT-1:0] tlb_ppn,
  input  logic [3:0]                 tlb_rd_en,
  input  logic [3:0]                 tlb_wr_en,
  input  logic                       tlb_fault_rd,
  input  logic                       tlb_fault_wr,
  output logic                       rsp_valid,
  output logic [PA_W-1:0]            rsp_paddr,
  output logic [2:0]                 rsp_fault,
  output logic                       fr_upd,
  output logic [VA_W-1:0]            fr_va,
  output logic [16:0]                fr_stat,
  output logic [VA_W-1:0]            fr_vaform,
  output logic [CNT_W-1:0]           cnt_rd_hit,
  output logic [CNT_W-1:0]           cnt_rd_miss,
  output logic [CNT_W-1:0]           cnt_rd_acv,
  output logic [CNT_W-1:0]           cnt_wr_hit,
  output logic [CNT_W-1:0]           cnt_wr_miss,
  output logic [CNT_W-1:0]           cnt_wr_acv
);
  localparam int VPN_W = VA_IMPL - PAGE_SHIFT;

  logic [MODE_W-1:0] eff_mode;
  logic              misaligned, va_ok, in_sp;
  logic [PA_W-1:0]   sp_paddr;
  logic              p_deny;
  fcode_t            p_code;
  logic [NFLAGS-1:0] p_flags;

  fcode_t            c_fault;
  logic [NFLAGS-1:0] c_flags;
  logic [PA_W-1:0]   c_paddr;
  logic              c_counted;
  int unsigned       c_kind;
  logic [NCNT-1:0]   cnt_inc;
  logic              c_upd;
  logic [VA_W-1:0]   vpn_form;

  logic [CNT_W-1:0]  cnt_q [NCNT];

  dxl_mode_sel u_mode (
    .pc_lsb   (pc_lsb),
    .use_alt  (req_altmode),
    .cur_mode (cur_mode),
    .alt_mode (alt_mode),
    .eff_mode (eff_mode)
  );

  dxl_addr_class #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_W(PA_W), .SIZE_W(SIZE_W),
    .SP_LO(SP_LO), .SP_HI(SP_HI), .SP_TAG(SP_TAG), .SP_EXT_BIT(SP_EXT_BIT)
  ) u_class (
    .vaddr      (req_vaddr),
    .size_log2  (req_size),
    .misaligned (misaligned),
    .va_ok      (va_ok),
    .in_sp      (in_sp),
    .sp_paddr   (sp_paddr)
  );

  dxl_perm_check u_perm (
    .is_write (req_write),
    .mode     (eff_mode),
    .rd_en    (tlb_rd_en),
    .wr_en    (tlb_wr_en),
    .trap_rd  (tlb_fault_rd),
    .trap_wr  (tlb_fault_wr),
    .deny     (p_deny),
    .code     (p_code),
    .flags    (p_flags)
  );

  // precedence chain of the translation checks
  always_comb begin
    c_fault   = FC_NONE;
    c_flags   = '0;
    c_paddr   = '0;
    c_counted = 1'b1;
    c_kind    = K_HIT;
    if (misaligned) begin
      c_fault       = FC_ALIGN;
      c_flags[FL_WR] = req_write;
      c_counted     = 1'b0;
    end else if (req_phys) begin
      c_paddr   = req_vaddr[PA_W-1:0];
      c_counted = 1'b0;
    end else if (!va_ok) begin
      c_fault          = FC_PAGE;
      c_flags[FL_WR]    = req_write;
      c_flags[FL_ACV]   = 1'b1;
      c_flags[FL_BADVA] = 1'b1;
      c_kind           = K_ACV;
    end else if (in_sp) begin
      if (eff_mode != MODE_KERNEL) begin
        c_fault        = FC_ACV;
        c_flags[FL_WR]  = req_write;
        c_flags[FL_ACV] = 1'b1;
        c_kind         = K_ACV;
      end else begin
        c_paddr = sp_paddr;
      end
    end else if (!tlb_hit) begin
      c_fault         = req_ptload ? FC_PMISS : FC_NMISS;
      c_flags[FL_WR]   = req_write;
      c_flags[FL_MISS] = 1'b1;
      c_kind          = K_MISS;
    end else if (p_deny) begin
      c_fault = p_code;
      c_flags = p_flags;
      c_kind  = K_ACV;
    end else begin
      c_paddr = {tlb_ppn, req_vaddr[PAGE_SHIFT-1:0]};
    end
  end

  always_comb begin
    cnt_inc = '0;
    if (req_valid && c_counted)
      cnt_inc[(req_write ? NKIND : 0) + c_kind] = 1'b1;
  end

  assign c_upd = req_valid && (c_fault != FC_NONE) &&
                 !req_misspec && !req_ptload && !req_nofault;
  assign vpn_form = VA_W'(req_vaddr[VA_IMPL-1:PAGE_SHIFT]) << 3;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= '0;
      fr_upd    <= 1'b0;
      fr_va     <= '0;
      fr_stat   <= '0;
      fr_vaform <= '0;
    end else begin
      rsp_valid <= req_valid;
      fr_upd    <= c_upd;
      if (req_valid) begin
        rsp_paddr <= c_paddr;
        rsp_fault <= c_fault;
      end
      if (c_upd) begin
        fr_va     <= req_vaddr;
        fr_stat   <= {req_opcode, req_regnum, c_flags};
        fr_vaform <= fmt_base | vpn_form;
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NCNT; gi++) begin : g_cnt
      dxl_sat_ctr #(.W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .inc   (cnt_inc[gi]),
        .count (cnt_q[gi])
      );
    end
  endgenerate

  assign cnt_rd_hit  = cnt_q[K_HIT];
  assign cnt_rd_miss = cnt_q[K_MISS];
  assign cnt_rd_acv  = cnt_q[K_ACV];
  assign cnt_wr_hit  = cnt_q[NKIND + K_HIT];
  assign cnt_wr_miss = cnt_q[NKIND + K_MISS];
  assign cnt_wr_acv  = cnt_q[NKIND + K_ACV];
endmodule

// File: rtl/data_xlate_checker.sv
module data_xlate_checker #(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 43,
  parameter int PA_W    = 44,
  parameter int SIZE_W  = 2,
  parameter int SP_LO   = 41,
  parameter int SP_HI   = 47,
  parameter int SP_TAG  = 126,
  parameter int CNT_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [VA_W-1:0]   req_vaddr,
  input logic [SIZE_W-1:0] req_size,
  input logic              req_phys,
  input logic              req_ptload,
  input logic              tlb_hit,
  input logic              rsp_valid,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic [2:0]        rsp_fault,
  input logic              fr_upd,
  input logic [VA_W-1:0]   fr_va,
  input logic [16:0]       fr_stat,
  input logic [CNT_W-1:0]  cnt_rd_hit,
  input logic [CNT_W-1:0]  cnt_wr_acv
);
  localparam int SP_W = SP_HI - SP_LO + 1;

  logic ck_mis, ck_ok, ck_sp;
  assign ck_mis = (req_vaddr & ((VA_W'(1) << req_size) - VA_W'(1))) != '0;
  assign ck_ok  = (&req_vaddr[VA_W-1:VA_IMPL-1]) || !(|req_vaddr[VA_W-1:VA_IMPL-1]);
  assign ck_sp  = req_vaddr[SP_HI:SP_LO] == SP_W'(SP_TAG);

  p_rsp_follows_r13: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_rsp_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_align_first_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ck_mis) |=> (rsp_fault == 3'd1));
  p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ck_mis && req_phys) |=>
      (rsp_fault == 3'd0 && rsp_paddr == $past(req_vaddr[PA_W-1:0])));
  p_miss_code_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ck_mis && !req_phys && ck_ok && !ck_sp && !tlb_hit) |=>
      (rsp_fault == ($past(req_ptload) ? 3'd5 : 3'd4)));
  p_fault_pa_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_paddr == '0));
  p_upd_on_fault_r11: assert property (@(posedge clk) disable iff (rst)
    fr_upd |-> (rsp_valid && rsp_fault != 3'd0));
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !fr_upd |-> ($stable(fr_va) && $stable(fr_stat)));
  p_no_wrap_hit_r12: assert property (@(posedge clk) disable iff (rst)
    cnt_rd_hit >= $past(cnt_rd_hit));
  p_no_wrap_acv_r12: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_acv >= $past(cnt_wr_acv));
endmodule

bind data_xlate data_xlate_checker #(
  .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_W(PA_W), .SIZE_W(SIZE_W),
  .SP_LO(SP_LO), .SP_HI(SP_HI), .SP_TAG(SP_TAG), .CNT_W(CNT_W)
) u_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_size(req_size), .req_phys(req_phys), .req_ptload(req_ptload),
  .tlb_hit(tlb_hit), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .fr_upd(fr_upd), .fr_va(fr_va), .fr_stat(fr_stat),
  .cnt_rd_hit(cnt_rd_hit), .cnt_wr_acv(cnt_wr_acv)
);

// File: tb/data_xlate_tb_top.sv
`timescale 1ns/1ps
module data_xlate_tb_top;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        req_valid = 0;
  logic [63:0] va = 0;
  logic [1:0]  sz = 0;
  logic        wr = 0, phys = 0, altreq = 0, ptl = 0, nof = 0, misp = 0, pc0 = 0;
  logic [1:0]  cmode = 0, amode = 0;
  logic [5:0]  op = 0;
  logic [4:0]  rg = 0;
  logic [63:0] base = 64'h0000_0002_0000_0000;
  logic        hit = 1;
  logic [30:0] ppn = 31'h1234_567;
  logic [3:0]  rde = 4'hF, wre = 4'hF;
  logic        frd = 0, fwr = 0;

  logic          rsp_valid, fr_upd;
  logic [43:0]   rsp_paddr;
  logic [2:0]    rsp_fault;
  logic [63:0]   fr_va, fr_vaform;
  logic [16:0]   fr_stat;
  logic [CW-1:0] c_rh, c_rm, c_ra, c_wh, c_wm, c_wa;

  data_xlate #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(va), .req_size(sz),
    .req_write(wr), .req_phys(phys), .req_altmode(altreq), .req_ptload(ptl),
    .req_nofault(nof), .req_misspec(misp), .cur_mode(cmode), .alt_mode(amode),
    .pc_lsb(pc0), .req_opcode(op), .req_regnum(rg), .fmt_base(base),
    .tlb_hit(hit), .tlb_ppn(ppn), .tlb_rd_en(rde), .tlb_wr_en(wre),
    .tlb_fault_rd(frd), .tlb_fault_wr(fwr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .fr_upd(fr_upd), .fr_va(fr_va), .fr_stat(fr_stat), .fr_vaform(fr_vaform),
    .cnt_rd_hit(c_rh), .cnt_rd_miss(c_rm), .cnt_rd_acv(c_ra),
    .cnt_wr_hit(c_wh), .cnt_wr_miss(c_wm), .cnt_wr_acv(c_wa)
  );

  int nchk = 0, nfail = 0, nreq = 0;
  int ecnt [6];
  logic [63:0] e_frva = 0, e_frform = 0;
  logic [16:0] e_frstat = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected result, derived from the requirement list
  task automatic run(string tag);
    logic mis, ok, sp;
    logic [1:0] em;
    logic [2:0] fc;
    logic [5:0] fl;
    logic [43:0] pa;
    int kind;
    logic upd;
    nreq++;
    op = 6'(nreq * 7);
    rg = 5'(nreq * 3);
    mis = (va & ((64'd1 << sz) - 64'd1)) != 0;
    ok  = (va[63:42] == '0) || (va[63:42] == '1);
    sp  = va[47:41] == 7'h7e;
    em  = pc0 ? (altreq ? amode : 2'd0) : cmode;           // R2
    fc = 0; fl = 0; pa = 0; kind = -1;
    if (mis) begin fc = 1; fl = {5'b0, wr}; end            // R1
    else if (phys) pa = va[43:0];                         // R3
    else if (!ok) begin fc = 3; fl = 6'h22 | {5'b0, wr}; kind = 2; end   // R4
    else if (sp) begin                                    // R5
      if (em != 0) begin fc = 2; fl = 6'h02 | {5'b0, wr}; kind = 2; end
      else begin pa = {{4{va[40]}}, va[39:0]}; kind = 0; end
    end else if (!hit) begin fc = ptl ? 3'd5 : 3'd4; fl = 6'h10 | {5'b0, wr}; kind = 1; end // R6
    else if (wr) begin                                    // R8
      if (!wre[em]) begin fc = 3; fl = fwr ? 6'h0B : 6'h03; kind = 2; end
      else if (fwr) begin fc = 3; fl = 6'h09; kind = 2; end
      else begin pa = {ppn, va[12:0]}; kind = 0; end
    end else begin                                        // R9
      if (!rde[em]) begin fc = 2; fl = frd ? 6'h06 : 6'h02; kind = 2; end
      else if (frd) begin fc = 3; fl = 6'h04; kind = 2; end
      else begin pa = {ppn, va[12:0]}; kind = 0; end
    end
    upd = (fc != 0) && !misp && !ptl && !nof;
    if (kind >= 0) begin
      int idx = (wr ? 3 : 0) + kind;
      if (ecnt[idx] < (1 << CW) - 1) ecnt[idx]++;
    end
    if (upd) begin
      e_frva   = va;
      e_frstat = {op, rg, fl};                            // R10
      e_frform = base | ({34'b0, va[42:13]} << 3);
    end
    @(negedge clk); req_valid = 1;
    @(posedge clk); #1;
    check({tag, " R13 rsp_valid"}, 64'(rsp_valid), 64'd1);
    check({tag, " fault"}, 64'(rsp_fault), 64'(fc));
    check({tag, " R7 paddr"}, 64'(rsp_paddr), 64'(pa));
    check({tag, " R11 fr_upd"}, 64'(fr_upd), 64'(upd));
    check({tag, " R11 fr_va"}, fr_va, e_frva);
    check({tag, " R10 fr_stat"}, 64'(fr_stat), 64'(e_frstat));
    check({tag, " R11 fr_vaform"}, fr_vaform, e_frform);
    @(negedge clk); req_valid = 0;
    @(posedge clk); #1;
    check({tag, " R13 idle"}, 64'(rsp_valid), 64'd0);
  endtask

  task automatic check_cnts(string tag);
    check({tag, " R12 rd_hit"},  64'(c_rh), 64'(ecnt[0]));
    check({tag, " R12 rd_miss"}, 64'(c_rm), 64'(ecnt[1]));
    check({tag, " R12 rd_acv"},  64'(c_ra), 64'(ecnt[2]));
    check({tag, " R12 wr_hit"},  64'(c_wh), 64'(ecnt[3]));
    check({tag, " R12 wr_miss"}, 64'(c_wm), 64'(ecnt[4]));
    check({tag, " R12 wr_acv"},  64'(c_wa), 64'(ecnt[5]));
  endtask

  task automatic defaults();
    sz = 3; wr = 0; phys = 0; altreq = 0; ptl = 0; nof = 0; misp = 0; pc0 = 0;
    cmode = 0; amode = 0; hit = 1; rde = 4'hF; wre = 4'hF; frd = 0; fwr = 0;
    va = 64'h0000_0012_3456_7000;
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) ecnt[i] = 0;
    defaults();
    repeat (3) @(posedge clk);
    #1;
    // R13: reset state
    check("R13 reset rsp_valid", 64'(rsp_valid), 0);
    check("R13 reset fr_stat", 64'(fr_stat), 0);
    check("R13 reset fr_va", fr_va, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    check_cnts("R13 reset");

    // R1: alignment against every size, offset, direction and bypass flag
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 8; o++)
        for (int w = 0; w < 2; w++)
          for (int p = 0; p < 2; p++) begin
            defaults(); sz = 2'(s); wr = w[0]; phys = p[0]; hit = o[1];
            va = 64'h0000_0012_3456_7000 | 64'(o);
            run("R1 align");
          end
    check_cnts("R1 sweep");

    // R2: mode override, one-hot read enable reveals effective mode
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 4; c++)
          for (int m = 0; m < 4; m++)
            for (int k = 0; k < 4; k++) begin
              defaults(); pc0 = a[0]; altreq = b[0]; cmode = 2'(c); amode = 2'(m);
              rde = 4'(1 << k); wr = k[0] & a[0]; wre = 4'(1 << k);
              run("R2 mode");
            end
    check_cnts("R2 sweep");

    // R9 / R8: permission and trap bits per mode
    for (int w = 0; w < 2; w++)
      for (int m = 0; m < 4; m++)
        for (int e = 0; e < 16; e++)
          for (int t = 0; t < 2; t++) begin
            defaults(); wr = w[0]; cmode = 2'(m);
            rde = 4'(e); wre = 4'(e); frd = t[0]; fwr = t[0];
            ppn = 31'(e * 977 + m);
            run(w ? "R8 store" : "R9 load");
          end
    check_cnts("R8 R9 sweep");

    // R6 and R11: misses crossed with suppression qualifiers
    for (int q = 0; q < 16; q++) begin
      defaults(); hit = 0; ptl = q[0]; nof = q[1]; misp = q[2]; wr = q[3];
      va = 64'h0000_0003_FFFF_E008 + 64'(q * 8);
      run("R6 miss");
      check_cnts("R6 R11 step");
    end

    // R4 and R5: bad addresses and superpage window per mode
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 2; w++)
        for (int x = 0; x < 3; x++) begin
          defaults(); cmode = 2'(m); wr = w[0]; hit = 0;
          case (x)
            0: va = 64'h0000_0400_0000_0040;
            1: va = 64'hFFFF_FC12_3456_7898;
            default: va = 64'hFFFF_FD12_3456_7898;
          endcase
          run(x == 0 ? "R4 badva" : "R5 superpage");
        end
    check_cnts("R4 R5 sweep");

    // R3: physical bypass ignores validity and translation inputs
    for (int i = 0; i < 6; i++) begin
      defaults(); phys = 1; hit = 0; rde = 0; wre = 0; wr = i[0];
      va = 64'h8000_0400_0000_0000 | 64'(i * 64'h1_1111_1118);
      run("R3 bypass");
    end
    check_cnts("R3 sweep");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule